// File: doc/BRIEF.md
# Configurable Stack Pointer Unit

This block keeps the pointer of a stack held in byte-addressed memory. It works out, for every push or pop request, the byte address the memory must access and the pointer value that follows. A two-bit mode input picks one of four disciplines. The pointer can be adjusted before or after the access. It can move toward higher or lower addresses. In a full discipline the pointer marks the most recent item. In an empty discipline it marks the next free slot.

A small configuration port loads a lower bound, an upper bound and a start address. Any request whose access would fall outside the bounds is blocked. So is any request that would push the pointer outside the address space. A blocked request leaves the pointer and the memory untouched and sets a sticky flag. The memory array and instruction decoding sit outside the block. The unit only drives the address and the write and read strobes.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals START_INIT, the lower bound is 0, the upper bound is all ones, the start register equals START_INIT, all three error flags are 0, and neither strobe is active while no request is present.
- R2: Mode 2'b00 (bit 1 = 0 descending, bit 0 = 0 full). A push accesses pointer-STEP and leaves the pointer there. A pop accesses the pointer and then adds STEP to it.
- R3: Mode 2'b01 (descending, empty). A push accesses the pointer and then subtracts STEP from it. A pop adds STEP to the pointer and accesses the new value.
- R4: Mode 2'b10 (ascending, full). A push adds STEP to the pointer and accesses the new value. A pop accesses the pointer and then subtracts STEP. Mode 2'b11 (ascending, empty): a push accesses the pointer and then adds STEP. A pop subtracts STEP and accesses the new value.
- R5: An accepted push raises mem_we and an accepted pop raises mem_re. Each strobe lasts one cycle. mem_addr is valid combinationally in the request cycle. The new pointer value appears after the next rising clock edge.
- R6: A request whose access address is above the upper bound is blocked: no strobe, pointer unchanged. hi_err is set at the next edge.
- R7: A request whose access address is below the lower bound is blocked in the same way and sets lo_err.
- R8: Push and pop asserted in the same cycle cause no strobe and leave the pointer unchanged. clash_err is set.
- R9: The error flags stay set until err_clr is high at a clock edge. If an error arises in the same cycle as err_clr, the flag is still set.
- R10: When cfg_we is high, cfg_sel selects the action: 0 loads the lower bound, 1 loads the upper bound, 2 loads the start register and the pointer together, and 3 reloads the pointer from the start register. During that cycle push and pop are ignored: no strobe and no flag.
- R11: A request whose next pointer would leave the range 0 to 2^ADDR_W-1 is blocked and does not wrap. A value above the range sets hi_err and a value below it sets lo_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Bit 1: 1 ascending, 0 descending. Bit 0: 1 empty, 0 full |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| err_clr | input | 1 | Clears the sticky error flags |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target select |
| cfg_data | input | ADDR_W | Configuration value |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_we | output | 1 | Memory write strobe for a push |
| mem_re | output | 1 | Memory read strobe for a pop |
| sp | output | ADDR_W | Current pointer |
| hi_err | output | 1 | Sticky flag: access or pointer above range |
| lo_err | output | 1 | Sticky flag: access or pointer below range |
| clash_err | output | 1 | Sticky flag: push and pop asserted together |

## Verification
The bench builds the unit with a 16-bit address, a step of 2 bytes and a start address of 0x0140. The 16-bit address lets directed cases put the pointer at 0x0000 and 0xFFFE, so both ends of the address space can be tested for wrap. In the random phase the bounds enclose a 32-word window. Random pushes and pops then fill and drain it often in all four modes. A behavioural memory with a shadow LIFO confirms that every pop returns the most recent value that was pushed and not yet popped.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int ADDR_W = 16,
  parameter int STEP = 2,
  parameter logic [ADDR_W-1:0] START_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              push,
  input  logic              pop,
  input  logic              err_clr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] sp,
  output logic              hi_err,
  output logic              lo_err,
  output logic              clash_err
);
  localparam int EW = ADDR_W + 2;
  localparam logic [EW-1:0] STEP_X = EW'(STEP);
  localparam logic [EW-1:0] TOP_X = {2'b00, {ADDR_W{1'b1}}};

  logic [ADDR_W-1:0] sp_q, base_q, limit_q, start_q;
  logic hi_q, lo_q, clash_q;

  wire asc   = mode[1];
  wire empty = mode[0];

  wire [EW-1:0] sp_x  = {2'b00, sp_q};
  wire          up    = push ? asc : ~asc;
  wire          pre   = push ? ~empty : empty;
  wire [EW-1:0] sp_nx = up ? sp_x + STEP_X : sp_x - STEP_X;
  wire [EW-1:0] acc   = pre ? sp_nx : sp_x;

  wire above = ($signed(acc) > $signed({2'b00, limit_q})) || ($signed(sp_nx) > $signed(TOP_X));
  wire below = ($signed(acc) < $signed({2'b00, base_q})) || sp_nx[EW-1];

  wire one_req = (push ^ pop) & ~cfg_we;
  wire clash   = push & pop & ~cfg_we;
  wire ok      = one_req & ~above & ~below;

  assign mem_addr  = acc[ADDR_W-1:0];
  assign mem_we    = ok & push;
  assign mem_re    = ok & pop;
  assign sp        = sp_q;
  assign hi_err    = hi_q;
  assign lo_err    = lo_q;
  assign clash_err = clash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= START_INIT;
      start_q <= START_INIT;
      base_q  <= '0;
      limit_q <= '1;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: base_q <= cfg_data;
        2'd1: limit_q <= cfg_data;
        2'd2: begin
          start_q <= cfg_data;
          sp_q    <= cfg_data;
        end
        default: sp_q <= start_q;
      endcase
    end else if (ok) begin
      sp_q <= sp_nx[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      hi_q    <= (hi_q & ~err_clr) | (one_req & above);
      lo_q    <= (lo_q & ~err_clr) | (one_req & below);
      clash_q <= (clash_q & ~err_clr) | clash;
    end
  end
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int STEP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              push,
  input logic              pop,
  input logic              err_clr,
  input logic              cfg_we,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] limit_q,
  input logic              hi_err,
  input logic              clash_err
);
  // R5
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R6
  in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr >= base_q && mem_addr <= limit_q));

  // R8
  clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !cfg_we) |=> (clash_err && sp == $past(sp)));

  // R9
  hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_err && !err_clr) |=> hi_err);

  // R7
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((push ^ pop) && !cfg_we && !mem_we && !mem_re) |=> sp == $past(sp));

  // R4
  asc_push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode[1]) |=> sp == ADDR_W'($past(sp) + ADDR_W'(STEP)));

  // R10
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !(mem_we || mem_re));
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .push(push), .pop(pop),
  .err_clr(err_clr), .cfg_we(cfg_we), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .sp(sp), .base_q(base_q), .limit_q(limit_q),
  .hi_err(hi_err), .clash_err(clash_err)
);

// File: tb/stack_ptr_unit_test.sv
`timescale 1ns/1ps
module stack_ptr_unit_test;
  localparam int AW = 16;
  localparam int ST = 2;
  localparam logic [15:0] SI = 16'h0140;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic push = 0, pop = 0, err_clr = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_data = 0;
  logic [15:0] mem_addr, sp;
  logic mem_we, mem_re, hi_err, lo_err, clash_err;

  always #2.5 clk = ~clk;

  stack_ptr_unit #(.ADDR_W(AW), .STEP(ST), .START_INIT(SI)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .push(push), .pop(pop),
    .err_clr(err_clr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .sp(sp),
    .hi_err(hi_err), .lo_err(lo_err), .clash_err(clash_err));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_sp, m_base, m_lim, m_start;
  bit m_hi, m_lo, m_cl;
  logic [15:0] mem [256];
  logic [15:0] shadow [$];

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void calc(input logic [1:0] md, input bit is_push, input int s,
                               output int acc, output int nsp);
    case ({md, is_push})
      3'b001: begin nsp = s - ST; acc = nsp; end
      3'b000: begin acc = s; nsp = s + ST; end
      3'b011: begin acc = s; nsp = s - ST; end
      3'b010: begin nsp = s + ST; acc = nsp; end
      3'b101: begin nsp = s + ST; acc = nsp; end
      3'b100: begin acc = s; nsp = s - ST; end
      3'b111: begin acc = s; nsp = s + ST; end
      default: begin nsp = s - ST; acc = nsp; end
    endcase
  endfunction

  task automatic check_state(string tag);
    chk({tag, " sp"}, sp, m_sp);
    chk({tag, " hi_err"}, hi_err, m_hi);
    chk({tag, " lo_err"}, lo_err, m_lo);
    chk({tag, " clash_err"}, clash_err, m_cl);
  endtask

  task automatic step(string tag, bit p, bit q, bit clr, bit cw, logic [1:0] sel, logic [15:0] d);
    int acc, nsp;
    bit req, above, below, ok;
    logic [15:0] val;
    push = p; pop = q; err_clr = clr; cfg_we = cw; cfg_sel = sel; cfg_data = d;
    #1;
    req = (p ^ q) && !cw;
    calc(mode, p, m_sp, acc, nsp);
    above = (acc > m_lim) || (nsp > 65535);
    below = (acc < m_base) || (nsp < 0);
    ok = req && !above && !below;
    chk({tag, " mem_we"}, mem_we, ok && p);
    chk({tag, " mem_re"}, mem_re, ok && q);
    if (ok) begin
      chk({tag, " mem_addr"}, mem_addr, acc);
      if (p) begin
        val = 16'($urandom);
        mem[acc & 255] = val;
        shadow.push_back(val);
      end else if (shadow.size() == 0) begin
        chk({tag, " R5 pop of empty shadow"}, 1, 0);
      end else begin
        chk({tag, " R5 LIFO data"}, mem[acc & 255], shadow.pop_back());
      end
      m_sp = nsp;
    end
    m_hi = (m_hi && !clr) || (req && above);
    m_lo = (m_lo && !clr) || (req && below);
    m_cl = (m_cl && !clr) || (p && q && !cw);
    if (cw) begin
      case (sel)
        2'd0: m_base = d;
        2'd1: m_lim = d;
        2'd2: begin m_start = d; m_sp = d; shadow.delete(); end
        default: begin m_sp = m_start; shadow.delete(); end
      endcase
    end
    @(negedge clk);
    push = 0; pop = 0; err_clr = 0; cfg_we = 0;
    check_state(tag);
  endtask

  task automatic setup(logic [1:0] md, int b, int l, int s);
    mode = md;
    step("R10 base", 0, 0, 1, 1, 2'd0, 16'(b));
    step("R10 limit", 0, 0, 0, 1, 2'd1, 16'(l));
    step("R10 start", 0, 0, 0, 1, 2'd2, 16'(s));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_sp = SI; m_start = SI; m_base = 0; m_lim = 65535;
    m_hi = 0; m_lo = 0; m_cl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");
    chk("R1 idle mem_we", mem_we, 0);
    chk("R1 idle mem_re", mem_re, 0);

    // R2 full descending, directed
    setup(2'b00, 16'h0100, 16'h013E, 16'h0140);
    step("R2 push", 1, 0, 0, 0, 0, 0);
    chk("R2 sp after push", sp, 16'h013E);
    step("R2 pop", 0, 1, 0, 0, 0, 0);
    step("R6 pop on empty FD", 0, 1, 0, 0, 0, 0);
    chk("R6 hi_err set", hi_err, 1);
    step("R9 hold", 0, 0, 0, 0, 0, 0);
    step("R9 clear", 0, 0, 1, 0, 0, 0);
    chk("R9 cleared", hi_err, 0);

    // R3 empty descending, directed
    setup(2'b01, 16'h0100, 16'h013E, 16'h013E);
    step("R3 push", 1, 0, 0, 0, 0, 0);
    chk("R3 sp after push", sp, 16'h013C);
    step("R3 pop", 0, 1, 0, 0, 0, 0);

    // R4 ascending modes, directed
    setup(2'b10, 16'h0100, 16'h013E, 16'h00FE);
    step("R4 FA push", 1, 0, 0, 0, 0, 0);
    chk("R4 FA sp", sp, 16'h0100);
    step("R4 FA pop", 0, 1, 0, 0, 0, 0);
    step("R7 FA pop empty", 0, 1, 0, 0, 0, 0);
    chk("R7 lo_err set", lo_err, 1);
    setup(2'b11, 16'h0100, 16'h013E, 16'h0100);
    step("R4 EA push", 1, 0, 0, 0, 0, 0);
    chk("R4 EA sp", sp, 16'h0102);
    step("R4 EA pop", 0, 1, 0, 0, 0, 0);

    // R8 clash, with R9 set-over-clear
    step("R8 clash", 1, 1, 0, 0, 0, 0);
    chk("R8 clash_err", clash_err, 1);
    step("R9 set wins", 1, 1, 1, 0, 0, 0);
    chk("R9 clash kept", clash_err, 1);
    step("R9 clr", 0, 0, 1, 0, 0, 0);

    // R10 cfg cycle masks a push, sel 3 reload
    step("R10 masked push", 1, 0, 0, 1, 2'd0, 16'h0100);
    step("R10 reload", 0, 0, 0, 1, 2'd3, 0);
    chk("R10 reload sp", sp, 16'h0100);

    // R11 wrap at both ends
    setup(2'b00, 16'h0000, 16'hFFFF, 16'h0000);
    step("R11 low wrap", 1, 0, 0, 0, 0, 0);
    chk("R11 lo_err", lo_err, 1);
    chk("R11 sp held low", sp, 0);
    setup(2'b11, 16'h0000, 16'hFFFF, 16'hFFFE);
    step("R11 high wrap", 1, 0, 0, 0, 0, 0);
    chk("R11 hi_err", hi_err, 1);
    chk("R11 sp held high", sp, 16'hFFFE);

    // random phase in all modes
    void'($urandom(32'd1234));
    for (int md = 0; md < 4; md++) begin
      int st0;
      case (md)
        0: st0 = 16'h0140;
        1: st0 = 16'h013E;
        2: st0 = 16'h00FE;
        default: st0 = 16'h0100;
      endcase
      setup(2'(md), 16'h0100, 16'h013E, st0);
      for (int i = 0; i < 1500; i++) begin
        int r = $urandom_range(0, 99);
        bit clr = ($urandom_range(0, 19) == 0);
        if (r < 48) step("R5 rnd push", 1, 0, clr, 0, 0, 0);
        else if (r < 90) step("R5 rnd pop", 0, 1, clr, 0, 0, 0);
        else if (r < 94) step("R8 rnd clash", 1, 1, clr, 0, 0, 0);
        else if (r < 97) step("R10 rnd masked", 1, 0, clr, 1, 2'd0, 16'h0100);
        else step("R5 rnd idle", 0, 0, clr, 0, 0, 0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule